// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits in front of a small word-addressed memory and serves two requesters. Each request carries a 2-bit opcode, an address and a write word. The opcode selects one of four operations: plain load, plain store, test-and-set or swap. The two atomic operations read the addressed word and then conditionally write it back. They return the value the word held before the operation. Software builds a spin lock from test-and-set and releases it with an ordinary store of zero.

Every accepted request runs through a single sequencer that has two memory phases: a read phase and then a write phase. While the sequencer is occupied, `busy` is high and no grant is issued. This means no other access can reach the memory between the read and the write of an atomic. When both requesters ask in the same idle cycle, requester 0 wins. A requester holds its request until it sees its grant bit. Exactly two cycles after the accepting edge, a one-cycle response pulse returns the result together with the identity of the requester.

Top module: `atom_rmw_top`

## Requirements
- R1: Opcode 2'b00 (load) returns the addressed word in `rsp_data` and leaves memory unchanged.
- R2: Opcode 2'b01 (store) writes `rqX_wdata` to the addressed word, and its response carries data zero.
- R3: Opcode 2'b10 (test-and-set) returns the old word and, when that word was zero, writes the value 1.
- R4: A test-and-set on a non-zero word returns that word and leaves it unchanged.
- R5: Opcode 2'b11 (swap) returns the old word and writes `rqX_wdata` in its place.
- R6: A request is accepted on a rising edge where its grant bit is high. `rsp_valid` is high for exactly the one cycle that follows the second rising edge after acceptance, with `rsp_id` naming the requester.
- R7: `busy` is high for the two cycles after the accepting edge. `rq_gnt` is zero whenever `busy` is high.
- R8: When both requesters are valid in an idle cycle, `rq_gnt` is 2'b01. At most one grant bit is ever set.
- R9: A request that waits behind an atomic operation on the same word observes memory only after that atomic's write has completed.
- R10: After reset, `busy`, `rsp_valid` and `rq_gnt` are low and every memory word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rq0_valid | input | 1 | Requester 0 request valid |
| rq0_op | input | 2 | Requester 0 opcode |
| rq0_addr | input | AW | Requester 0 word address |
| rq0_wdata | input | DW | Requester 0 write word |
| rq1_valid | input | 1 | Requester 1 request valid |
| rq1_op | input | 2 | Requester 1 opcode |
| rq1_addr | input | AW | Requester 1 word address |
| rq1_wdata | input | DW | Requester 1 write word |
| rq_gnt | output | 2 | One-hot grant; the request is taken at the next edge |
| busy | output | 1 | Sequencer occupied by an operation |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_id | output | 1 | Requester that the response belongs to |
| rsp_data | output | DW | Returned word |

## Verification
The bench aims at the test-and-set condition from both sides: on a zero word and on a word already set. A unit that writes unconditionally would turn a held value of 5 into 1. Two requesters then race for the same lock in one cycle. A broken priority or a missing busy block would hand both of them a zero, or answer requester 1 first. The bench also checks the exact cycle and width of the response pulse, so an extra or missing pipeline stage shows up as a response in the wrong cycle. Lock release by a plain store and swap's write-back are each followed by a load, so a lost or misdirected write is visible at the ports.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAS   = 2'b10,
    OP_SWAP  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_READ  = 2'b01,
    SQ_WRITE = 2'b10
  } seq_state_e;
endpackage

// File: rtl/atom_rst_sync.sv
module atom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/atom_arb.sv
module atom_arb #(
  parameter int N  = 2,
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][1:0]    op_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [N-1:0][DW-1:0] wdata_i,
  output logic [N-1:0]         gnt_o,
  output logic                 any_o,
  output logic [IDW-1:0]       sel_id_o,
  output logic [1:0]           sel_op_o,
  output logic [AW-1:0]        sel_addr_o,
  output logic [DW-1:0]        sel_wdata_o
);
  // Walk from highest to lowest index so the lowest valid requester wins.
  always_comb begin
    gnt_o       = '0;
    sel_id_o    = '0;
    sel_op_o    = '0;
    sel_addr_o  = '0;
    sel_wdata_o = '0;
    if (en) begin
      for (int i = N-1; i >= 0; i--) begin
        if (valid_i[i]) begin
          gnt_o       = '0;
          gnt_o[i]    = 1'b1;
          sel_id_o    = IDW'(i);
          sel_op_o    = op_i[i];
          sel_addr_o  = addr_i[i];
          sel_wdata_o = wdata_i[i];
        end
      end
    end
  end

  assign any_o = |gnt_o;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R8
  AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid_i[0]) |-> gnt_o[0]); // R8
endmodule

// File: rtl/atom_mem.sv
module atom_mem #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] word_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (we) begin
      word_q[addr] <= wdata;
    end
  end

  assign rdata = word_q[addr];
endmodule

// File: rtl/atom_seq.sv
module atom_seq
  import atom_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int IDW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_i,
  input  logic [IDW-1:0] id_i,
  input  logic [1:0]     op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           busy_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           rsp_valid_o,
  output logic [IDW-1:0] rsp_id_o,
  output logic [DW-1:0]  rsp_data_o
);
  seq_state_e     state_q, state_d;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [IDW-1:0] id_q;
  logic [DW-1:0]  old_q;
  logic           cap_en, old_en;
  logic           rsp_valid_d;
  logic [DW-1:0]  rsp_data_d;

  // Next-state and datapath decisions
  always_comb begin
    state_d     = state_q;
    cap_en      = 1'b0;
    old_en      = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = wdata_q;
    rsp_valid_d = 1'b0;
    rsp_data_d  = '0;
    case (state_q)
      SQ_IDLE: begin
        if (take_i) begin
          cap_en  = 1'b1;
          state_d = SQ_READ;
        end
      end
      SQ_READ: begin
        old_en  = 1'b1;
        state_d = SQ_WRITE;
      end
      SQ_WRITE: begin
        rsp_valid_d = 1'b1;
        state_d     = SQ_IDLE;
        case (op_q)
          OP_LOAD:  rsp_data_d = old_q;
          OP_STORE: mem_we_o   = 1'b1;
          OP_TAS: begin
            rsp_data_d  = old_q;
            mem_we_o    = (old_q == '0);
            mem_wdata_o = DW'(1);
          end
          OP_SWAP: begin
            rsp_data_d = old_q;
            mem_we_o   = 1'b1;
          end
          default: ;
        endcase
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      rsp_valid_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      id_q    <= '0;
    end else if (cap_en) begin
      op_q    <= op_e'(op_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      id_q    <= id_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (old_en) old_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_o <= '0;
      rsp_id_o   <= '0;
    end else if (rsp_valid_d) begin
      rsp_data_o <= rsp_data_d;
      rsp_id_o   <= id_q;
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign mem_addr_o = addr_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o); // R6
  AST_RSP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(state_q == SQ_WRITE)); // R6
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(state_q == SQ_READ)); // R9
  AST_TAS_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WRITE && op_q == OP_TAS && old_q != '0) |-> !mem_we_o); // R4
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WRITE && op_q == OP_LOAD) |-> !mem_we_o); // R1
endmodule

// File: rtl/atom_rmw_top.sv
module atom_rmw_top #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq0_valid,
  input  logic [1:0]    rq0_op,
  input  logic [AW-1:0] rq0_addr,
  input  logic [DW-1:0] rq0_wdata,
  input  logic          rq1_valid,
  input  logic [1:0]    rq1_op,
  input  logic [AW-1:0] rq1_addr,
  input  logic [DW-1:0] rq1_wdata,
  output logic [1:0]    rq_gnt,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_id,
  output logic [DW-1:0] rsp_data
);
  localparam int NRQ = 2;
  localparam int IDW = 1;

  logic                   rst_s_n;
  logic [NRQ-1:0]         v_vec;
  logic [NRQ-1:0][1:0]    op_vec;
  logic [NRQ-1:0][AW-1:0] addr_vec;
  logic [NRQ-1:0][DW-1:0] wd_vec;
  logic                   any_gnt;
  logic [IDW-1:0]         sel_id;
  logic [1:0]             sel_op;
  logic [AW-1:0]          sel_addr;
  logic [DW-1:0]          sel_wdata;
  logic [AW-1:0]          m_addr;
  logic                   m_we;
  logic [DW-1:0]          m_wdata, m_rdata;

  assign v_vec    = {rq1_valid, rq0_valid};
  assign op_vec   = {rq1_op, rq0_op};
  assign addr_vec = {rq1_addr, rq0_addr};
  assign wd_vec   = {rq1_wdata, rq0_wdata};

  atom_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_s_n)
  );

  atom_arb #(.N(NRQ), .AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_s_n), .en(!busy),
    .valid_i(v_vec), .op_i(op_vec), .addr_i(addr_vec), .wdata_i(wd_vec),
    .gnt_o(rq_gnt), .any_o(any_gnt), .sel_id_o(sel_id), .sel_op_o(sel_op),
    .sel_addr_o(sel_addr), .sel_wdata_o(sel_wdata)
  );

  atom_seq #(.AW(AW), .DW(DW), .IDW(IDW)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .take_i(any_gnt), .id_i(sel_id),
    .op_i(sel_op), .addr_i(sel_addr), .wdata_i(sel_wdata), .busy_o(busy),
    .mem_addr_o(m_addr), .mem_we_o(m_we), .mem_wdata_o(m_wdata),
    .mem_rdata_i(m_rdata), .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id),
    .rsp_data_o(rsp_data)
  );

  atom_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_s_n), .addr(m_addr), .we(m_we),
    .wdata(m_wdata), .rdata(m_rdata)
  );

  AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |-> (rq_gnt == '0)); // R7
  AST_BUSY_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rq_gnt != '0) |=> busy); // R7
endmodule

// File: tb/tb_atom_rmw_top.sv
module tb_atom_rmw_top;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rq0_valid, rq1_valid;
  logic [1:0]    rq0_op, rq1_op;
  logic [AW-1:0] rq0_addr, rq1_addr;
  logic [DW-1:0] rq0_wdata, rq1_wdata;
  logic [1:0]    rq_gnt;
  logic          busy, rsp_valid, rsp_id;
  logic [DW-1:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  atom_rmw_top #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .rq0_valid(rq0_valid), .rq0_op(rq0_op), .rq0_addr(rq0_addr), .rq0_wdata(rq0_wdata),
    .rq1_valid(rq1_valid), .rq1_op(rq1_op), .rq1_addr(rq1_addr), .rq1_wdata(rq1_wdata),
    .rq_gnt(rq_gnt), .busy(busy), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data)
  );

  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int id, input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (id == 0) begin
      rq0_valid = v; rq0_op = op; rq0_addr = a; rq0_wdata = d;
    end else begin
      rq1_valid = v; rq1_op = op; rq1_addr = a; rq1_wdata = d;
    end
  endtask

  // One operation from one requester on an idle unit; full timing checked.
  task automatic run_op(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req,
                        output logic [DW-1:0] got);
    @(negedge clk);
    drive(id, 1'b1, op, a, d);
    #1;
    chk("R8 grant", rq_gnt, (id == 0) ? 2'b01 : 2'b10);
    @(posedge clk); @(negedge clk);
    drive(id, 1'b0, 2'b00, '0, '0);
    chk("R7 busy after accept", busy, 1'b1);
    chk("R7 no grant busy", rq_gnt, 2'b00);
    chk("R6 no early rsp", rsp_valid, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R6 no early rsp 2", rsp_valid, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R6 rsp valid", rsp_valid, 1'b1);
    chk("R6 rsp id", rsp_id, id[0]);
    chk("R7 busy low at rsp", busy, 1'b0);
    got = rsp_data;
    @(posedge clk); @(negedge clk);
    chk("R6 rsp one cycle", rsp_valid, 1'b0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R10 busy", busy, 1'b0);
    chk("R10 rsp_valid", rsp_valid, 1'b0);
    chk("R10 gnt", rq_gnt, 2'b00);
    run_op(0, 2'b00, 4'd9, '0, "R10", v);
    chk("R10 mem zero", v, 0);
  endtask

  task automatic t_store_load();
    logic [DW-1:0] v;
    run_op(1, 2'b01, 4'd2, 32'hCAFE_0123, "R2", v);
    chk("R2 store rsp zero", v, 0);
    run_op(0, 2'b00, 4'd2, 32'h5555_5555, "R1", v);
    chk("R1 load value", v, 32'hCAFE_0123);
    run_op(0, 2'b00, 4'd2, '0, "R1", v);
    chk("R1 load no change", v, 32'hCAFE_0123);
  endtask

  task automatic t_tas();
    logic [DW-1:0] v;
    run_op(0, 2'b10, 4'd5, 32'hFFFF_FFFF, "R3", v);
    chk("R3 tas old zero", v, 0);
    run_op(0, 2'b00, 4'd5, '0, "R3", v);
    chk("R3 tas wrote one", v, 1);
    run_op(1, 2'b10, 4'd5, '0, "R4", v);
    chk("R4 tas held returns 1", v, 1);
    run_op(0, 2'b01, 4'd6, 32'd5, "R4", v);
    run_op(1, 2'b10, 4'd6, '0, "R4", v);
    chk("R4 tas returns 5", v, 5);
    run_op(1, 2'b00, 4'd6, '0, "R4", v);
    chk("R4 word unchanged", v, 5);
    // lock release by plain store of zero
    run_op(0, 2'b01, 4'd5, 32'd0, "R2", v);
    run_op(1, 2'b10, 4'd5, '0, "R3", v);
    chk("R3 tas after release", v, 0);
  endtask

  task automatic t_swap();
    logic [DW-1:0] v;
    run_op(0, 2'b01, 4'd11, 32'h0000_00AA, "R5", v);
    run_op(1, 2'b11, 4'd11, 32'h1234_5678, "R5", v);
    chk("R5 swap old", v, 32'h0000_00AA);
    run_op(0, 2'b00, 4'd11, '0, "R5", v);
    chk("R5 swap new", v, 32'h1234_5678);
  endtask

  // Both requesters race for the same free lock in one cycle.
  task automatic t_race();
    @(negedge clk);
    drive(0, 1'b1, 2'b10, 4'd13, '0);
    drive(1, 1'b1, 2'b10, 4'd13, '0);
    #1;
    chk("R8 priority gnt", rq_gnt, 2'b01);
    @(posedge clk); @(negedge clk);
    drive(0, 1'b0, 2'b00, '0, '0);
    chk("R7 waiter blocked", rq_gnt, 2'b00);
    @(posedge clk); @(negedge clk);
    chk("R7 waiter still blocked", rq_gnt, 2'b00);
    @(posedge clk); @(negedge clk);
    chk("R8 first rsp valid", rsp_valid, 1'b1);
    chk("R8 first rsp id", rsp_id, 1'b0);
    chk("R9 winner sees free", rsp_data, 0);
    chk("R8 second gnt", rq_gnt, 2'b10);
    @(posedge clk); @(negedge clk);
    drive(1, 1'b0, 2'b00, '0, '0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 loser rsp valid", rsp_valid, 1'b1);
    chk("R9 loser rsp id", rsp_id, 1'b1);
    chk("R9 loser sees held", rsp_data, 1);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    drive(0, 1'b0, 2'b00, '0, '0);
    drive(1, 1'b0, 2'b00, '0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_store_load();
    t_tas();
    t_swap();
    t_race();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule